// File: doc/BRIEF.md
# Backup Supply Source Selector

This block decides which source powers a battery-backed memory supply rail. It takes digitized comparator flags and drives a one-hot select to an external analog switch. The sources are the main supply, a primary backup cell and a secondary backup cell; a fourth code selects nothing. While the main supply is above the cell voltage the rail follows the main supply. Below that point the primary cell feeds the rail while it stays above its 2.5 V health threshold. When the primary cell sags, the secondary cell takes over. A cell whose presence flag is low is never chosen.

To save the cells while no data needs retaining, the block has a storage (isolated) state in which no source is connected. Two events put it there. The first is fitting a cell while the main supply is absent. The second is a qualified request on the chip-enable line: a mid-level flag held long enough inside the window that runs from power-fail detection to the switch-over point. A glitch above the mid band anywhere in that window cancels the request. The return of the main supply leaves the isolated state, so the next power loss connects a cell at once. Every change from one real source to another passes through one cycle with nothing selected.

Top module: `bkup_src_sel`

## Requirements
- R1: During and directly after reset `src_sel_o` is 4'b1000 (nothing selected) and `isolated_o` is 0.
- R2: `src_sel_o` is a 4-bit one-hot code: bit 0 main supply, bit 1 cell 1, bit 2 cell 2, bit 3 nothing; exactly one bit is set in every cycle.
- R3: While `main_above_cell_i` is 1, the selection settles on main supply (4'b0001) and `isolated_o` is 0 one cycle later.
- R4: With the main supply below the cells and the block not isolated, cell 1 is chosen when `cell1_here_i` and `cell1_ok_i` are both 1.
- R5: With cell 1 present but not ok, cell 2 is chosen if `cell2_here_i` is 1; if cell 2 is absent, cell 1 stays in use.
- R6: A cell whose presence flag is 0 is never selected; with no cell present and the main supply low, the selection is 4'b1000.
- R7: A change between two different real sources inserts exactly one cycle of 4'b1000. A change from or to 4'b1000 takes effect in one cycle.
- R8: A 0-to-1 change of either presence flag while `main_above_cell_i` is 0 sets `isolated_o` on the next edge, and the selection becomes 4'b1000.
- R9: The isolation window is the span where `pwr_fail_i` and `main_above_cell_i` are both 1. If `ce_mid_i` is 1 for QUAL_CYC consecutive cycles inside it, `isolated_o` is set on the edge at which `main_above_cell_i` is first seen at 0.
- R10: A cycle with `ce_mid_i` at 0 inside the window restarts the consecutive count from zero.
- R11: Any cycle with `ce_over_i` at 1 inside the window voids the request for that window.
- R12: `isolated_o` clears one edge after `main_above_cell_i` is 1. At the next loss of the main supply the proper cell is connected with no isolation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_above_cell_i | input | 1 | Main supply is above the backup cell voltage |
| pwr_fail_i | input | 1 | Main supply is below the power-fail threshold |
| cell1_ok_i | input | 1 | Cell 1 is above 2.5 V |
| cell1_here_i | input | 1 | Cell 1 is fitted |
| cell2_here_i | input | 1 | Cell 2 is fitted |
| ce_mid_i | input | 1 | Chip-enable line sits in the mid-level band |
| ce_over_i | input | 1 | Chip-enable line is above the mid band's upper bound |
| src_sel_o | output | 4 | One-hot source select (main, cell 1, cell 2, nothing) |
| isolated_o | output | 1 | Storage (isolated) state is active |

## Verification
An input change is seen at the next rising edge. A change from or to the idle code, and the isolated flag, appear right after that edge. A change between two real sources shows the idle code after that edge and the new source one edge later. The isolation request needs QUAL_CYC edges of mid-level before the edge where the main supply is seen low. The bench drives inputs on the falling edge and advances its own expected-state function once per rising edge. It compares both outputs at the following falling edge, so each result is judged in the cycle it is due, over directed sequences and a seeded random run.

// File: rtl/bss_pkg.sv
package bss_pkg;

   localparam int N_CELL = 2;
   localparam int SEL_W  = 4;

   typedef enum logic [SEL_W-1:0] {
      SRC_MAIN  = 4'b0001,
      SRC_CELL1 = 4'b0010,
      SRC_CELL2 = 4'b0100,
      SRC_NONE  = 4'b1000
   } src_e;

endpackage

// File: rtl/bss_attach_det.sv
module bss_attach_det
   import bss_pkg::*;
#(
   parameter int CELLS = N_CELL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CELLS-1:0] here,
   input  logic             main_ok,
   output logic             attach
);

   if (CELLS < 1) begin : g_bad_cells
      $error("bss_attach_det: CELLS must be at least 1");
   end

   logic [CELLS-1:0] rise;

   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= here[c];
      end
      assign rise[c] = here[c] & ~prev_q;
   end

   // a cell fitted while the main supply carries the rail does not isolate
   assign attach = (|rise) & ~main_ok;

endmodule

// File: rtl/bss_iso_qual.sv
module bss_iso_qual #(
   parameter int QUAL_CYC = 175
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_fail,
   input  logic main_ok,
   input  logic ce_mid,
   input  logic ce_over,
   output logic iso_req
);

   localparam int CNT_W = $clog2(QUAL_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYC - 1);

   if (QUAL_CYC < 2) begin : g_bad_qual
      $error("bss_iso_qual: QUAL_CYC must be at least 2");
   end

   logic             win, win_q;
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q, void_q;

   assign win = pwr_fail & main_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q   <= 1'b0;
         cnt_q   <= '0;
         armed_q <= 1'b0;
         void_q  <= 1'b0;
      end else begin
         win_q <= win;
         if (!win) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            void_q  <= 1'b0;
         end else begin
            if (ce_over) void_q <= 1'b1;
            if (!ce_mid) begin
               cnt_q <= '0;
            end else if (!armed_q) begin
               if (cnt_q == LAST) armed_q <= 1'b1;
               else               cnt_q   <= cnt_q + 1'b1;
            end
         end
      end
   end

   // the window closes when the main supply drops under the cells
   assign iso_req = win_q & ~main_ok & armed_q & ~void_q;

endmodule

// File: rtl/bss_src_arb.sv
module bss_src_arb
   import bss_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_ok,
   input  logic             iso_set,
   input  logic             c1_here,
   input  logic             c1_ok,
   input  logic             c2_here,
   output logic [SEL_W-1:0] sel,
   output logic             iso
);

   logic iso_q, iso_nxt;
   src_e sel_q, want, sel_nxt;

   always_comb begin
      iso_nxt = main_ok ? 1'b0 : (iso_q | iso_set);
   end

   always_comb begin
      if (main_ok)                want = SRC_MAIN;
      else if (iso_nxt)           want = SRC_NONE;
      else if (c1_here && c1_ok)  want = SRC_CELL1;
      else if (c2_here)           want = SRC_CELL2;
      else if (c1_here)           want = SRC_CELL1;
      else                        want = SRC_NONE;
   end

   // break before make between two real sources
   always_comb begin
      if (sel_q != SRC_NONE && want != SRC_NONE && want != sel_q)
         sel_nxt = SRC_NONE;
      else
         sel_nxt = want;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iso_q <= 1'b0;
         sel_q <= SRC_NONE;
      end else begin
         iso_q <= iso_nxt;
         sel_q <= sel_nxt;
      end
   end

   assign sel = sel_q;
   assign iso = iso_q;

endmodule

// File: rtl/bkup_src_sel.sv
module bkup_src_sel
   import bss_pkg::*;
#(
   parameter int QUAL_CYC = 175
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_above_cell_i,
   input  logic             pwr_fail_i,
   input  logic             cell1_ok_i,
   input  logic             cell1_here_i,
   input  logic             cell2_here_i,
   input  logic             ce_mid_i,
   input  logic             ce_over_i,
   output logic [SEL_W-1:0] src_sel_o,
   output logic             isolated_o
);

   logic attach, iso_req;

   bss_attach_det #(.CELLS(N_CELL)) u_att (
      .clk     (clk),
      .rst_n   (rst_n),
      .here    ({cell2_here_i, cell1_here_i}),
      .main_ok (main_above_cell_i),
      .attach  (attach)
   );

   bss_iso_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_fail (pwr_fail_i),
      .main_ok  (main_above_cell_i),
      .ce_mid   (ce_mid_i),
      .ce_over  (ce_over_i),
      .iso_req  (iso_req)
   );

   bss_src_arb u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .main_ok (main_above_cell_i),
      .iso_set (attach | iso_req),
      .c1_here (cell1_here_i),
      .c1_ok   (cell1_ok_i),
      .c2_here (cell2_here_i),
      .sel     (src_sel_o),
      .iso     (isolated_o)
   );

endmodule

// File: rtl/bss_chk.sv
module bss_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       main_ok,
   input logic       c1_here,
   input logic       c2_here,
   input logic [3:0] sel,
   input logic       iso
);

   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel) == 1);

   p_main_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
      main_ok |=> (sel[0] || sel[3]));

   p_no_absent1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !c1_here |=> !sel[1]);

   p_no_absent2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !c2_here |=> !sel[2]);

   p_break_make_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel[3] |=> (sel == $past(sel) || sel[3]));

   p_iso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iso |-> sel[3]);

   p_main_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      main_ok |=> !iso);

endmodule

bind bkup_src_sel bss_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .main_ok (main_above_cell_i),
   .c1_here (cell1_here_i),
   .c2_here (cell2_here_i),
   .sel     (src_sel_o),
   .iso     (isolated_o)
);

// File: tb/sim_bkup_src_sel.sv
module sim_bkup_src_sel;

   localparam int Q = 6;
   localparam logic [3:0] E_MAIN = 4'b0001, E_C1 = 4'b0010,
                          E_C2 = 4'b0100, E_NONE = 4'b1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic main_ok = 1'b0, pf = 1'b1, ok1 = 1'b1, h1 = 1'b0, h2 = 1'b0;
   logic mid = 1'b0, over = 1'b0;
   logic [3:0] sel;
   logic iso;

   int vecs = 0, bad = 0;
   bit done = 1'b0;

   // expected state
   logic [3:0] m_sel = E_NONE;
   logic m_iso = 1'b0, m_p1 = 1'b0, m_p2 = 1'b0, m_win = 1'b0;
   logic m_armed = 1'b0, m_void = 1'b0;
   int m_cnt = 0;

   always #2 clk = ~clk;

   bkup_src_sel #(.QUAL_CYC(Q)) u0 (
      .clk(clk), .rst_n(rst_n), .main_above_cell_i(main_ok),
      .pwr_fail_i(pf), .cell1_ok_i(ok1), .cell1_here_i(h1),
      .cell2_here_i(h2), .ce_mid_i(mid), .ce_over_i(over),
      .src_sel_o(sel), .isolated_o(iso));

   function automatic logic [3:0] pick(input logic m, input logic i,
         input logic a1, input logic k1, input logic a2);
      if (m)            return E_MAIN;
      if (i)            return E_NONE;
      if (a1 && k1)     return E_C1;
      if (a2)           return E_C2;
      if (a1)           return E_C1;
      return E_NONE;
   endfunction

   task automatic model_step();
      logic attach, req, iso_n;
      logic [3:0] w;
      if (!rst_n) begin
         m_sel = E_NONE; m_iso = 0; m_p1 = 0; m_p2 = 0; m_win = 0;
         m_armed = 0; m_void = 0; m_cnt = 0;
         return;
      end
      attach = ((h1 && !m_p1) || (h2 && !m_p2)) && !main_ok;
      req    = m_win && !main_ok && m_armed && !m_void;
      iso_n  = main_ok ? 1'b0 : (m_iso || attach || req);
      w      = pick(main_ok, iso_n, h1, ok1, h2);
      if (m_sel != E_NONE && w != E_NONE && w != m_sel) m_sel = E_NONE;
      else m_sel = w;
      m_iso = iso_n;
      if (!(pf && main_ok)) begin
         m_cnt = 0; m_armed = 0; m_void = 0;
      end else begin
         if (over) m_void = 1;
         if (!mid) m_cnt = 0;
         else if (!m_armed) begin
            m_cnt++;
            if (m_cnt == Q) m_armed = 1;
         end
      end
      m_win = pf && main_ok;
      m_p1 = h1; m_p2 = h2;
   endtask

   task automatic cyc(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      vecs++;
      if (sel !== m_sel || iso !== m_iso) begin
         bad++;
         $display("FAIL %s: sel=%b exp=%b iso=%b exp=%b", tag, sel, m_sel, iso, m_iso);
      end
   endtask

   task automatic cycn(input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(tag);
   endtask

   // explicit expectation on top of the model
   task automatic expect_now(input string tag, input logic [3:0] es, input logic ei);
      vecs++;
      if (sel !== es || iso !== ei) begin
         bad++;
         $display("FAIL %s: sel=%b exp=%b iso=%b exp=%b", tag, sel, es, iso, ei);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_2201));
      // R1 reset state
      h1 = 1; h2 = 1; ok1 = 1; main_ok = 1; pf = 0;
      cycn(3, "R1 reset");
      expect_now("R1 reset idle", E_NONE, 1'b0);
      rst_n = 1;
      // R3 main supply: NONE -> MAIN in one edge
      cyc("R3 main after reset");
      expect_now("R3 main selected", E_MAIN, 1'b0);
      cycn(3, "R3 main hold");
      // R4 power loss, no request: MAIN -> NONE -> C1 (R7)
      pf = 1; cycn(2, "R4 window");
      mid = 0; main_ok = 0;
      cyc("R7 idle gap");
      expect_now("R7 idle gap", E_NONE, 1'b0);
      cyc("R4 cell1");
      expect_now("R4 cell1 feeds", E_C1, 1'b0);
      // R5 fall-over
      ok1 = 0; cycn(2, "R5 fall-over");
      expect_now("R5 cell2 feeds", E_C2, 1'b0);
      h2 = 0; cycn(2, "R5 cell2 gone, cell1 kept");
      expect_now("R5 cell1 kept", E_C1, 1'b0);
      // R6 no cell present
      h1 = 0; cyc("R6 none present");
      expect_now("R6 none present", E_NONE, 1'b0);
      // R8 attach while main low
      ok1 = 1; h1 = 1; cyc("R8 attach");
      expect_now("R8 attach isolates", E_NONE, 1'b1);
      cycn(3, "R8 hold");
      // R12 main returns, clears, then loss connects at once
      main_ok = 1; cyc("R12 main back");
      expect_now("R12 iso cleared", E_MAIN, 1'b0);
      pf = 1; cycn(2, "R12 window");
      main_ok = 0; cycn(2, "R12 reconnect");
      expect_now("R12 cell1 direct", E_C1, 1'b0);
      // R9 qualified request
      main_ok = 1; pf = 0; cycn(3, "R9 setup");
      pf = 1; mid = 1; cycn(Q, "R9 qualify");
      mid = 0; main_ok = 0; cyc("R9 close");
      expect_now("R9 isolated", E_NONE, 1'b1);
      cycn(2, "R9 hold");
      // R10 restart on dropout
      main_ok = 1; pf = 0; cycn(3, "R10 setup");
      pf = 1; mid = 1; cycn(Q-1, "R10 part1");
      mid = 0; cyc("R10 drop");
      mid = 1; cycn(Q-1, "R10 part2");
      mid = 0; main_ok = 0; cycn(2, "R10 close");
      expect_now("R10 not isolated", E_C1, 1'b0);
      // R11 over-level voids
      main_ok = 1; pf = 0; cycn(3, "R11 setup");
      pf = 1; mid = 1; cycn(Q+1, "R11 qualify");
      over = 1; cyc("R11 glitch");
      over = 0; cycn(2, "R11 after");
      mid = 0; main_ok = 0; cycn(2, "R11 close");
      expect_now("R11 voided", E_C1, 1'b0);
      // random run
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 25 == 0) main_ok = ~main_ok;
         if (!main_ok) pf = 1;
         else if ($urandom % 10 == 0) pf = ~pf;
         mid  = ($urandom % 8) != 0;
         over = ($urandom % 60) == 0;
         if ($urandom % 12 == 0) ok1 = ~ok1;
         if ($urandom % 70 == 0) h1 = ~h1;
         if ($urandom % 70 == 0) h2 = ~h2;
         cyc("R2/R3/R4/R5/R7 random");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run hung, exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

endmodule